// File: doc/BRIEF.md
# Wavetable Pin Waveform Formatter

This block formats one tester channel pin, one tester cycle at a time. Each cycle it takes an index into a table of waveform shapes. The selected shape lists what each drive edge does (drive low, drive high, release, or nothing) and what each receive edge does (expect low, expect high, don't care, or nothing). A second, independent table holds the tick at which each numbered edge fires, measured from the start of the cycle, along with the cycle length. Because the two tables are separate, the same shapes can be replayed with new timing, and the same timing can serve many shapes. Several device cycles can be packed into one tester cycle by giving a shape several data edges.

The drive side produces a pin level and an enable. The receive side samples the device's response at each strobe tick and compares it with the expected level. A mismatch raises a one-cycle fail flag and bumps a saturating fail count. Both tables are loaded through plain write ports. Indices arrive through a valid/ready pair. When no index is waiting at a cycle boundary, the formatter idles and keeps the pin as it was.

Top module: `fmt_pin_formatter`

## Requirements
- R1: While reset is held, and right after it, drv_en, drv_val and fail_pulse are 0, fail_count is 0 and vec_ready is 1. In the timing table every slot resets to all ones.
- R2: An index is accepted on a clock edge where vec_valid and vec_ready are both 1. The accepted cycle lasts P clocks, where P is the period slot. vec_ready is 0 during its first P-1 clocks and 1 during its last clock, so the next index can be taken back to back.
- R3: A shape entry holds drive edge k in bits [2k+1:2k]. Code 01 drives 0 with drv_en=1, code 10 drives 1 with drv_en=1, code 00 does nothing. If edge k's time is t, the new pin state appears after the (t+1)-th clock edge that follows the accepting edge.
- R4: Drive code 11 releases the pin: drv_en goes to 0 and drv_val keeps its last value.
- R5: An edge whose time is greater than or equal to P never fires. This covers both drive and receive edges.
- R6: When several drive edges with non-zero codes fall on the same tick, the highest-numbered edge decides the pin state.
- R7: Receive edge j sits in bits [2*N_DRV+2j+1 : 2*N_DRV+2j]. Code 01 expects dut_in=0, code 10 expects dut_in=1, and codes 11 and 00 never fail. dut_in is sampled on the same clock edge at which a drive edge of equal time would take effect.
- R8: Every tick on which at least one strobe mismatches gives exactly one clock of fail_pulse=1 and adds 1 to fail_count. The count saturates at all ones.
- R9: If no index is valid at a cycle boundary, the formatter goes idle. While idle no edge fires, drv_en and drv_val hold, and vec_ready stays 1.
- R10: The shape entry is captured when its index is accepted. A write to that entry during the cycle only affects later cycles that select it.
- R11: Timing slots are addressed as follows: 0..N_DRV-1 hold drive edge times, N_DRV..N_DRV+N_RCV-1 hold receive edge times, and N_DRV+N_RCV holds the period. Writes to higher addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wt_we | input | 1 | Shape table write strobe |
| wt_addr | input | IDX_W | Shape table write address |
| wt_data | input | 2*(N_DRV+N_RCV) | Shape entry to write |
| tm_we | input | 1 | Timing table write strobe |
| tm_addr | input | clog2(N_DRV+N_RCV+1) | Timing slot address |
| tm_data | input | TICK_W | Tick value to write |
| vec_valid | input | 1 | Index available |
| vec_idx | input | IDX_W | Shape index for the next cycle |
| vec_ready | output | 1 | Formatter can take an index this clock |
| dut_in | input | 1 | Sampled device response |
| drv_val | output | 1 | Pin drive level |
| drv_en | output | 1 | Pin drive enable |
| fail_pulse | output | 1 | One clock per failing strobe tick |
| fail_count | output | FAIL_W | Saturating count of failing ticks |

## Verification
The bench first replays shapes under a realistic long period. These include single-edge drive, two drives in one cycle, release followed by high and low strobes, and don't-care strobes. Together they separate edge ordering, release handling and the pass/fail sense. It also places edges exactly at the period and one tick before it, which tells an off-by-one period test apart from a correct one. A sweep then runs 64 arithmetically generated shapes against one-edge-per-tick timing and four response patterns; this exposes any mix-up of edge numbering or code meaning. Piling all drive edges onto one tick exposes the priority order, and a long run of failing strobes drives the counter into saturation.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
   typedef enum logic [1:0] {
      DRV_NOP = 2'b00,
      DRV_LO  = 2'b01,
      DRV_HI  = 2'b10,
      DRV_OFF = 2'b11
   } drv_code_e;

   typedef enum logic [1:0] {
      RCV_NOP = 2'b00,
      RCV_LO  = 2'b01,
      RCV_HI  = 2'b10,
      RCV_DC  = 2'b11
   } rcv_code_e;
endpackage

// File: rtl/fmt_wavetable.sv
module fmt_wavetable #(
   parameter int IDX_W   = 8,
   parameter int ENTRY_W = 32
) (
   input  logic               clk,
   input  logic               we,
   input  logic [IDX_W-1:0]   waddr,
   input  logic [ENTRY_W-1:0] wdata,
   input  logic [IDX_W-1:0]   raddr,
   output logic [ENTRY_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [ENTRY_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/fmt_edge_times.sv
module fmt_edge_times #(
   parameter int N_DRV  = 8,
   parameter int N_RCV  = 8,
   parameter int TICK_W = 8,
   parameter int TA_W   = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [TA_W-1:0]               addr,
   input  logic [TICK_W-1:0]             data,
   output logic [N_DRV-1:0][TICK_W-1:0]  drv_t,
   output logic [N_RCV-1:0][TICK_W-1:0]  rcv_t,
   output logic [TICK_W-1:0]             period
);
   localparam int N_SLOT = N_DRV + N_RCV + 1;

   logic [TICK_W-1:0] slot_q [N_SLOT];

   for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         slot_q[s] <= '1;
         else if (we && addr == TA_W'(s))    slot_q[s] <= data;
      end
   end

   for (genvar d = 0; d < N_DRV; d++) begin : g_drv
      assign drv_t[d] = slot_q[d];
   end

   for (genvar r = 0; r < N_RCV; r++) begin : g_rcv
      assign rcv_t[r] = slot_q[N_DRV + r];
   end

   assign period = slot_q[N_DRV + N_RCV];
endmodule

// File: rtl/fmt_drive_resolve.sv
module fmt_drive_resolve
   import fmt_pkg::*;
#(
   parameter int N_DRV  = 8,
   parameter int TICK_W = 8
) (
   input  logic [N_DRV-1:0][1:0]         code,
   input  logic [N_DRV-1:0][TICK_W-1:0]  t,
   input  logic [TICK_W-1:0]             cnt,
   input  logic [TICK_W-1:0]             period,
   output logic                          fire,
   output logic [1:0]                    win_code
);
   logic [N_DRV-1:0] hit;

   for (genvar k = 0; k < N_DRV; k++) begin : g_hit
      assign hit[k] = (code[k] != DRV_NOP) && (t[k] == cnt) && (t[k] < period);
   end

   // ascending scan: a later (higher-numbered) edge overrides
   always_comb begin
      win_code = DRV_NOP;
      for (int k = 0; k < N_DRV; k++) begin
         if (hit[k]) win_code = code[k];
      end
   end

   assign fire = |hit;
endmodule

// File: rtl/fmt_strobe_cmp.sv
module fmt_strobe_cmp
   import fmt_pkg::*;
#(
   parameter int N_RCV  = 8,
   parameter int TICK_W = 8
) (
   input  logic [N_RCV-1:0][1:0]         code,
   input  logic [N_RCV-1:0][TICK_W-1:0]  t,
   input  logic [TICK_W-1:0]             cnt,
   input  logic [TICK_W-1:0]             period,
   input  logic                          din,
   output logic                          fail
);
   logic [N_RCV-1:0] bad;

   for (genvar j = 0; j < N_RCV; j++) begin : g_bad
      logic due;
      assign due    = (t[j] == cnt) && (t[j] < period);
      assign bad[j] = due && (((code[j] == RCV_LO) && din) ||
                              ((code[j] == RCV_HI) && !din));
   end

   assign fail = |bad;
endmodule

// File: rtl/fmt_pin_formatter.sv
module fmt_pin_formatter
   import fmt_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int N_DRV  = 8,
   parameter int N_RCV  = 8,
   parameter int TICK_W = 8,
   parameter int FAIL_W = 8,
   localparam int ENTRY_W = 2 * (N_DRV + N_RCV),
   localparam int TA_W    = $clog2(N_DRV + N_RCV + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wt_we,
   input  logic [IDX_W-1:0]   wt_addr,
   input  logic [ENTRY_W-1:0] wt_data,
   input  logic               tm_we,
   input  logic [TA_W-1:0]    tm_addr,
   input  logic [TICK_W-1:0]  tm_data,
   input  logic               vec_valid,
   input  logic [IDX_W-1:0]   vec_idx,
   output logic               vec_ready,
   input  logic               dut_in,
   output logic               drv_val,
   output logic               drv_en,
   output logic               fail_pulse,
   output logic [FAIL_W-1:0]  fail_count
);
   if (IDX_W < 1 || IDX_W > 10) begin : g_chk_idx
      $error("IDX_W out of range");
   end
   if (N_DRV < 1 || N_DRV > 16) begin : g_chk_drv
      $error("N_DRV out of range");
   end
   if (N_RCV < 1 || N_RCV > 16) begin : g_chk_rcv
      $error("N_RCV out of range");
   end
   if (TICK_W < 2 || TICK_W > 16) begin : g_chk_tick
      $error("TICK_W out of range");
   end
   if (FAIL_W < 1) begin : g_chk_fail
      $error("FAIL_W must be positive");
   end

   logic [ENTRY_W-1:0]           rd_entry;
   logic [ENTRY_W-1:0]           entry_q;
   logic [N_DRV-1:0][TICK_W-1:0] drv_t;
   logic [N_RCV-1:0][TICK_W-1:0] rcv_t;
   logic [TICK_W-1:0]            period;
   logic [N_DRV-1:0][1:0]        drv_code;
   logic [N_RCV-1:0][1:0]        rcv_code;
   logic [TICK_W-1:0]            cnt_q;
   logic                         active;
   logic                         last_tick;
   logic                         accept;
   logic                         fire;
   logic [1:0]                   win_code;
   logic                         strobe_fail;
   logic                         drv_val_q, drv_en_q, fail_q;
   logic [FAIL_W-1:0]            fail_cnt_q;

   fmt_wavetable #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_wt (
      .clk(clk), .we(wt_we), .waddr(wt_addr), .wdata(wt_data),
      .raddr(vec_idx), .rdata(rd_entry)
   );

   fmt_edge_times #(.N_DRV(N_DRV), .N_RCV(N_RCV), .TICK_W(TICK_W), .TA_W(TA_W)) u_tm (
      .clk(clk), .rst_n(rst_n), .we(tm_we), .addr(tm_addr), .data(tm_data),
      .drv_t(drv_t), .rcv_t(rcv_t), .period(period)
   );

   assign drv_code = entry_q[2*N_DRV-1:0];
   assign rcv_code = entry_q[ENTRY_W-1:2*N_DRV];

   fmt_drive_resolve #(.N_DRV(N_DRV), .TICK_W(TICK_W)) u_drv (
      .code(drv_code), .t(drv_t), .cnt(cnt_q), .period(period),
      .fire(fire), .win_code(win_code)
   );

   fmt_strobe_cmp #(.N_RCV(N_RCV), .TICK_W(TICK_W)) u_rcv (
      .code(rcv_code), .t(rcv_t), .cnt(cnt_q), .period(period),
      .din(dut_in), .fail(strobe_fail)
   );

   assign last_tick = (cnt_q == period - TICK_W'(1));
   assign vec_ready = !active || last_tick;
   assign accept    = vec_valid && vec_ready;

   // cycle sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         cnt_q   <= '0;
         entry_q <= '0;
      end else if (accept) begin
         active  <= 1'b1;
         cnt_q   <= '0;
         entry_q <= rd_entry;
      end else if (active && last_tick) begin
         active  <= 1'b0;
      end else if (active) begin
         cnt_q   <= cnt_q + TICK_W'(1);
      end
   end

   // pin state and fail tracking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_val_q  <= 1'b0;
         drv_en_q   <= 1'b0;
         fail_q     <= 1'b0;
         fail_cnt_q <= '0;
      end else begin
         if (active && fire) begin
            unique case (win_code)
               DRV_LO:  begin drv_en_q <= 1'b1; drv_val_q <= 1'b0; end
               DRV_HI:  begin drv_en_q <= 1'b1; drv_val_q <= 1'b1; end
               DRV_OFF: drv_en_q <= 1'b0;
               default: ;
            endcase
         end
         fail_q <= active && strobe_fail;
         if (active && strobe_fail && fail_cnt_q != '1)
            fail_cnt_q <= fail_cnt_q + FAIL_W'(1);
      end
   end

   assign drv_val    = drv_val_q;
   assign drv_en     = drv_en_q;
   assign fail_pulse = fail_q;
   assign fail_count = fail_cnt_q;
endmodule

// File: rtl/fmt_pin_formatter_chk.sv
module fmt_pin_formatter_chk #(
   parameter int FAIL_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vec_valid,
   input logic              vec_ready,
   input logic              active,
   input logic              drv_en,
   input logic              drv_val,
   input logic              fail_pulse,
   input logic [FAIL_W-1:0] fail_count
);
   localparam logic [FAIL_W-1:0] CNT_MAX = '1;

   a_r1_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (!drv_en && !drv_val && !fail_pulse && fail_count == '0 && vec_ready));

   a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && vec_ready) |=> active);

   a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !vec_valid) |=> ##1 ($stable(drv_en) && $stable(drv_val) && !fail_pulse));

   a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_count != $past(fail_count)) |->
         (fail_pulse && fail_count == FAIL_W'($past(fail_count) + FAIL_W'(1))));

   a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_count == CNT_MAX) |=> (fail_count == CNT_MAX));

   a_r7_fail_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      fail_pulse |-> $past(active));
endmodule

bind fmt_pin_formatter fmt_pin_formatter_chk #(.FAIL_W(FAIL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
   .active(active), .drv_en(drv_en), .drv_val(drv_val),
   .fail_pulse(fail_pulse), .fail_count(fail_count)
);

// File: tb/test_fmt_pin_formatter.sv
module test_fmt_pin_formatter;
   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wt_we = 1'b0;
   logic [7:0]  wt_addr = '0;
   logic [31:0] wt_data = '0;
   logic        tm_we = 1'b0;
   logic [4:0]  tm_addr = '0;
   logic [7:0]  tm_data = '0;
   logic        vec_valid = 1'b0;
   logic [7:0]  vec_idx = '0;
   logic        vec_ready;
   logic        dut_in = 1'b0;
   logic        drv_val, drv_en, fail_pulse;
   logic [7:0]  fail_count;

   fmt_pin_formatter i_fmt_pin_formatter (
      .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_addr(wt_addr), .wt_data(wt_data),
      .tm_we(tm_we), .tm_addr(tm_addr), .tm_data(tm_data),
      .vec_valid(vec_valid), .vec_idx(vec_idx), .vec_ready(vec_ready),
      .dut_in(dut_in), .drv_val(drv_val), .drv_en(drv_en),
      .fail_pulse(fail_pulse), .fail_count(fail_count)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;

   // bench-side model state
   logic [31:0] m_wt [256];
   logic [7:0]  m_tm [32];
   logic        ex_en = 0, ex_val = 0, ex_pulse = 0;
   int          ex_cnt = 0;
   logic        pv = 0;
   logic [31:0] pe;
   int          pt;
   logic        pd;

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT) begin
         n_fails++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected below %0d", cyc, WD_LIMIT);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   task automatic chk(input string tag, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, got, exp, $time);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "drv_en", int'(drv_en), int'(ex_en));
      if (ex_en) chk(tag, "drv_val", int'(drv_val), int'(ex_val));
      chk(tag, "fail_pulse", int'(fail_pulse), int'(ex_pulse));
      chk(tag, "fail_count", int'(fail_count), ex_cnt);
   endtask

   // model of one tick, from the edge/strobe rules
   task automatic apply_tick(input logic [31:0] e, input int t, input logic d);
      int p = int'(m_tm[16]);
      logic f = 0;
      for (int k = 0; k < 8; k++) begin
         int c = int'(e[2*k +: 2]);
         if (c != 0 && int'(m_tm[k]) == t && int'(m_tm[k]) < p) begin
            if (c == 1) begin ex_en = 1; ex_val = 0; end
            else if (c == 2) begin ex_en = 1; ex_val = 1; end
            else ex_en = 0;
         end
      end
      for (int j = 0; j < 8; j++) begin
         int c = int'(e[16 + 2*j +: 2]);
         if (int'(m_tm[8+j]) == t && int'(m_tm[8+j]) < p) begin
            if ((c == 1 && d) || (c == 2 && !d)) f = 1;
         end
      end
      ex_pulse = f;
      if (f && ex_cnt < 255) ex_cnt++;
   endtask

   task automatic step_edge(input string tag);
      @(posedge clk);
      if (pv) apply_tick(pe, pt, pd);
      else ex_pulse = 0;
      pv = 0;
      @(negedge clk);
      compare(tag);
   endtask

   function automatic logic din_of(input int mode, input int t);
      case (mode)
         0: return 1'b0;
         1: return 1'b1;
         2: return t[0];
         default: return t[1] ^ t[2];
      endcase
   endfunction

   task automatic wt_wr(input int a, input logic [31:0] d);
      wt_we = 1; wt_addr = 8'(a); wt_data = d;
      step_edge("R9");
      wt_we = 0;
      m_wt[a] = d;
   endtask

   task automatic tm_wr(input int a, input int d);
      tm_we = 1; tm_addr = 5'(a); tm_data = 8'(d);
      step_edge("R11");
      tm_we = 0;
      m_tm[a] = 8'(d);
   endtask

   task automatic idle(input int n);
      vec_valid = 0;
      for (int i = 0; i < n; i++) begin
         step_edge("R9");
         chk("R9", "vec_ready idle", int'(vec_ready), 1);
      end
   endtask

   // called at a negedge in an interval where vec_ready must be 1
   task automatic play(input int idx, input int dmode, input bit modify, input string tag);
      int p = int'(m_tm[16]);
      logic [31:0] ent = m_wt[idx];
      chk("R2", "vec_ready at boundary", int'(vec_ready), 1);
      vec_valid = 1; vec_idx = 8'(idx);
      for (int t = 0; t < p; t++) begin
         step_edge(tag);
         if (t == 0) vec_valid = 0;
         if (modify && t == 2) begin
            wt_we = 1; wt_addr = 8'(idx); wt_data = ~ent;
            m_wt[idx] = ~ent;
         end
         if (modify && t == 3) wt_we = 0;
         if (t < p - 1) chk("R2", "vec_ready mid-cycle", int'(vec_ready), 0);
         dut_in = din_of(dmode, t);
         pv = 1; pe = ent; pt = t; pd = dut_in;
      end
   endtask

   initial begin
      for (int a = 0; a < 32; a++) m_tm[a] = 8'hFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", "drv_en", int'(drv_en), 0);
      chk("R1", "drv_val", int'(drv_val), 0);
      chk("R1", "fail_pulse", int'(fail_pulse), 0);
      chk("R1", "fail_count", int'(fail_count), 0);
      chk("R1", "vec_ready", int'(vec_ready), 1);
      rst_n = 1;

      // long-period timing with edges at and just below the period (R5, R11)
      tm_wr(0, 0);  tm_wr(1, 5);  tm_wr(2, 10); tm_wr(3, 20);
      tm_wr(4, 25); tm_wr(5, 40); tm_wr(6, 45); tm_wr(7, 44);
      tm_wr(8, 30); tm_wr(9, 40);
      tm_wr(16, 45);
      for (int a = 17; a < 32; a++) begin
         tm_wr(a, 0);
         m_tm[a] = 8'hFF; // R11: write to unused slot must leave behaviour unchanged
      end
      wt_wr(0, 32'h0000_0001);  // edge0 low
      wt_wr(1, 32'h0000_0002);  // edge0 high
      wt_wr(2, 32'h0000_0480);  // edge3 high, edge5 low
      wt_wr(3, 32'h0006_000C);  // release, expect H then L
      wt_wr(4, 32'h0005_000C);  // release, expect L twice
      wt_wr(5, 32'h0000_6002);  // edge6 at period (ignored), edge7 low at 44
      wt_wr(6, 32'h000F_0008);  // edge1 high, don't-care strobes
      play(1, 0, 0, "R3");
      play(0, 0, 0, "R3");
      play(2, 0, 0, "R3/R11");
      play(3, 2, 0, "R4/R7");
      play(3, 1, 0, "R4/R7/R8");
      play(4, 0, 0, "R7");
      play(4, 1, 0, "R7/R8");
      play(5, 0, 0, "R5");
      play(6, 3, 0, "R7");
      idle(4);
      play(1, 0, 0, "R9");
      idle(2);

      // sweep: one edge per tick, period 8
      for (int k = 0; k < 8; k++) tm_wr(k, k);
      for (int j = 0; j < 8; j++) tm_wr(8 + j, j);
      tm_wr(16, 8);
      for (int i = 0; i < 64; i++)
         wt_wr(64 + i, 32'(i) * 32'h9E37_79B1 ^ (32'(i) << 7));
      for (int i = 0; i < 64; i++) play(64 + i, i % 4, 0, "R3/R4/R7/R8");
      idle(2);

      // all drive edges on tick 3, all strobes on tick 5
      for (int k = 0; k < 8; k++) tm_wr(k, 3);
      for (int j = 0; j < 8; j++) tm_wr(8 + j, 5);
      for (int i = 0; i < 24; i++) play(64 + i, i % 4, 0, "R6/R7");
      idle(2);

      // entry rewritten mid-cycle, then replayed
      play(70, 2, 1, "R10");
      play(70, 2, 0, "R10");
      idle(2);

      // saturation: every tick fails
      for (int k = 0; k < 8; k++) tm_wr(k, k);
      for (int j = 0; j < 8; j++) tm_wr(8 + j, j);
      wt_wr(200, 32'hAAAA_0000);
      for (int i = 0; i < 40; i++) play(200, 0, 0, "R8");
      idle(3);
      chk("R8", "saturated count", int'(fail_count), 255);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule